// File: doc/BRIEF.md
# Flit-Level Stall Wrapper Controller

This block wraps a fixed-latency router so that it behaves as a stallable process. Its neighbours may then run at slightly different rates while traffic stays aligned to flit boundaries. Every input port has a small FIFO with a word counter. Every output port has a FIFO with a counter of space that has not yet been promised to any flit. A central controller fires only when every input FIFO holds a whole flit and every output has room for a whole flit. Each fire runs for one flit cycle of `FLIT_WORDS` clock cycles. During those cycles it pops one word per cycle from every input into the router together, and it reserves the matching output space at the same moment.

The router itself is modelled as a pure delay of `ROUTER_LAT` cycles, with input port p feeding output port p. A copy of the fire signal, delayed by that same latency, writes the router output into the output FIFOs. An empty token is a word whose valid bit (bit `DATA_W`) is low. It travels through the wrapper like any other word and counts toward the firing rule. Right after reset, the wrapper writes `INIT_TOKENS` empty flits into every output FIFO, one word per cycle, so that the neighbours can start without deadlock.

Top module: `stall_wrapper`

## Requirements
- R1: While rst_ni is low, fire_o is low and every out_avail_o bit is low; input and output FIFOs come out of reset empty.
- R2: For the first INIT_TOKENS*FLIT_WORDS cycles after reset release, each output FIFO is written one all-zero word per cycle and fire_o stays low; with defaults, both outputs show an all-zero word from the fourth cycle onward when nothing drains them.
- R3: A flit cycle starts only when every input FIFO holds at least FLIT_WORDS words and every output has at least FLIT_WORDS unreserved word slots; if any port falls short, no port fires.
- R4: Once started, fire_o stays high for exactly FLIT_WORDS consecutive cycles; readiness is tested again only in the cycle after the last one, so back-to-back flit cycles are possible.
- R5: In every fire cycle, exactly one word is popped from each input FIFO in arrival order.
- R6: An output's unreserved count falls by one for each word forwarded into the router, at forwarding time, and rises by one for each word drained; a flit cycle can therefore be blocked while the output FIFO itself is not yet full.
- R7: A word forwarded in fire cycle t is written into output FIFO p (from input p) at the end of cycle t+ROUTER_LAT, and becomes visible at out_word_o in cycle t+ROUTER_LAT+1 if that FIFO was empty; per-port order is kept.
- R8: Words whose bit DATA_W is 0 (empty tokens) are counted, forwarded and stored exactly like data words, with all bits unchanged.
- R9: A push into an input FIFO holding FIFO_FLITS*FLIT_WORDS words, in a cycle without a pop, is dropped.
- R10: A pop of an empty output FIFO has no effect.
- R11: An output FIFO is never written while full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_push_i | input | NP | Per-input word write strobe |
| in_word_i | input | NP*(DATA_W+1) | Per-input word; bit DATA_W is the valid bit |
| out_pop_i | input | NP | Per-output drain strobe from the downstream side |
| out_word_o | output | NP*(DATA_W+1) | Head word of each output FIFO |
| out_avail_o | output | NP | Output FIFO holds at least one word |
| fire_o | output | 1 | Flit cycle in progress; pops all inputs |

## Verification
The bench goes after these corner cases:
- Inputs holding one word short of a flit, and a single starved input while the others hold flits. A design that checks readiness per port, or with an off-by-one threshold, would fire early here.
- An output whose FIFO still has free entries while its unreserved space is already used up. A design that reserves space only when words land would fire into a FIFO that then overflows.
- Words dropped at a full input. If a dropped word were stored anyway, a later flit would be misaligned, and that shows up as an unexpected extra fire.
- The exact cycle in which the first forwarded word appears, which catches a wrong delay on the fire copy.
- Empty tokens. They must be forwarded unchanged, with the valid bit still clear.

// File: rtl/stall_wrap_pkg.sv
package stall_wrap_pkg;
  typedef enum logic {
    CM_INIT = 1'b0,
    CM_RUN  = 1'b1
  } ctrl_mode_e;
endpackage

// File: rtl/sw_in_port.sv
module sw_in_port #(
  parameter int WORD_W     = 9,
  parameter int DEPTH      = 6,
  parameter int FLIT_WORDS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] head_o,
  output logic              ready_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;
  logic              full, push_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && (!full || pop_i);
  assign head_o  = mem_q[rp_q];
  assign ready_o = (cnt_q >= CW'(FLIT_WORDS));

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_i)   rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_i);
    end
  end

  AST_IN_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0); // R5
  AST_IN_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i) |=> cnt_q == CW'(DEPTH)); // R9
endmodule

// File: rtl/sw_out_port.sv
module sw_out_port #(
  parameter int WORD_W     = 9,
  parameter int DEPTH      = 6,
  parameter int FLIT_WORDS = 3,
  parameter int INIT_WORDS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              reserve_i,
  input  logic              pop_i,
  output logic [WORD_W-1:0] word_o,
  output logic              avail_o,
  output logic              ready_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q, space_q;
  logic              pop_ok;

  assign pop_ok  = pop_i && (cnt_q != '0);
  assign avail_o = (cnt_q != '0);
  assign word_o  = mem_q[rp_q];
  assign ready_o = (space_q >= CW'(FLIT_WORDS));

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wp_q] <= wr_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      space_q <= CW'(DEPTH - INIT_WORDS); // init tokens pre-reserved
    end else begin
      if (wr_i)   wp_q <= (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_ok) rp_q <= (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q   <= cnt_q + CW'(wr_i) - CW'(pop_ok);
      space_q <= space_q + CW'(pop_ok) - CW'(reserve_i);
    end
  end

  AST_OUT_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !pop_ok) |-> cnt_q != CW'(DEPTH)); // R11
  AST_OUT_SPACE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(space_q) + int'(cnt_q)) <= DEPTH); // R6
  AST_OUT_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && cnt_q == '0 && !wr_i) |=> cnt_q == '0); // R10
endmodule

// File: rtl/sw_fire_ctrl.sv
module sw_fire_ctrl
  import stall_wrap_pkg::*;
#(
  parameter int FLIT_WORDS = 3,
  parameter int INIT_WORDS = 3,
  parameter int LAT        = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  output logic fire_o,
  output logic init_o,
  output logic wr_o
);
  localparam int PHW = (FLIT_WORDS > 1) ? $clog2(FLIT_WORDS) : 1;
  localparam int IW  = $clog2(INIT_WORDS + 2);

  ctrl_mode_e     mode_q;
  logic [IW-1:0]  init_q;
  logic [PHW-1:0] ph_q;
  logic [LAT-1:0] sr_q;

  assign init_o = (mode_q == CM_INIT);
  // mid-flit: keep firing; at boundary: fire only if all ports ready
  assign fire_o = !init_o && ((ph_q != '0) || ready_i);
  assign wr_o   = sr_q[LAT-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= (INIT_WORDS > 0) ? CM_INIT : CM_RUN;
      init_q <= IW'(INIT_WORDS);
      ph_q   <= '0;
      sr_q   <= '0;
    end else begin
      if (init_o) begin
        init_q <= init_q - 1'b1;
        if (init_q == IW'(1)) mode_q <= CM_RUN;
      end
      if (fire_o) ph_q <= (ph_q == PHW'(FLIT_WORDS - 1)) ? '0 : ph_q + 1'b1;
      else        ph_q <= '0;
      sr_q <= (sr_q << 1) | LAT'(fire_o);
    end
  end

  AST_FIRE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fire_o) |=> fire_o); // R4
  AST_INIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_o |=> !wr_o || !init_o); // R2
endmodule

// File: rtl/sw_router_pipe.sv
module sw_router_pipe #(
  parameter int NP     = 2,
  parameter int WORD_W = 9,
  parameter int LAT    = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NP-1:0][WORD_W-1:0] word_i,
  output logic [NP-1:0][WORD_W-1:0] word_o
);
  logic [NP-1:0][WORD_W-1:0] stg_q [LAT];

  for (genvar k = 0; k < LAT; k++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[k] <= '0;
      else if (k == 0) stg_q[k] <= word_i;
      else             stg_q[k] <= stg_q[(k == 0) ? 0 : k - 1];
    end
  end

  assign word_o = stg_q[LAT-1];
endmodule

// File: rtl/stall_wrapper.sv
module stall_wrapper #(
  parameter int NP          = 2,
  parameter int DATA_W      = 8,
  parameter int FLIT_WORDS  = 3,
  parameter int FIFO_FLITS  = 2,
  parameter int ROUTER_LAT  = 2,
  parameter int INIT_TOKENS = 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NP-1:0]             in_push_i,
  input  logic [NP-1:0][DATA_W:0]   in_word_i,
  input  logic [NP-1:0]             out_pop_i,
  output logic [NP-1:0][DATA_W:0]   out_word_o,
  output logic [NP-1:0]             out_avail_o,
  output logic                      fire_o
);
  localparam int WORD_W     = DATA_W + 1;
  localparam int DEPTH      = FLIT_WORDS * FIFO_FLITS;
  localparam int INIT_WORDS = INIT_TOKENS * FLIT_WORDS;

  logic [NP-1:0]             in_ready, out_ready;
  logic [NP-1:0][WORD_W-1:0] in_head, rtr_out;
  logic                      fire, init, wr_dly, all_ready;

  assign all_ready = (&in_ready) && (&out_ready);
  assign fire_o    = fire;

  for (genvar p = 0; p < NP; p++) begin : g_in
    sw_in_port #(.WORD_W(WORD_W), .DEPTH(DEPTH), .FLIT_WORDS(FLIT_WORDS)) u_in (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_push_i[p]),
      .word_i  (in_word_i[p]),
      .pop_i   (fire),
      .head_o  (in_head[p]),
      .ready_o (in_ready[p])
    );
  end

  sw_fire_ctrl #(.FLIT_WORDS(FLIT_WORDS), .INIT_WORDS(INIT_WORDS), .LAT(ROUTER_LAT)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (all_ready),
    .fire_o  (fire),
    .init_o  (init),
    .wr_o    (wr_dly)
  );

  sw_router_pipe #(.NP(NP), .WORD_W(WORD_W), .LAT(ROUTER_LAT)) u_rtr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .word_i (in_head),
    .word_o (rtr_out)
  );

  for (genvar p = 0; p < NP; p++) begin : g_out
    sw_out_port #(.WORD_W(WORD_W), .DEPTH(DEPTH), .FLIT_WORDS(FLIT_WORDS),
                  .INIT_WORDS(INIT_WORDS)) u_out (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (init || wr_dly),
      .wr_word_i (init ? '0 : rtr_out[p]),
      .reserve_i (fire),
      .pop_i     (out_pop_i[p]),
      .word_o    (out_word_o[p]),
      .avail_o   (out_avail_o[p]),
      .ready_o   (out_ready[p])
    );
  end
endmodule

// File: tb/stall_wrapper_tb.sv
module stall_wrapper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2, DATA_W = 8, WORD_W = 9, FW = 3, DEPTH = 6, LAT = 2, INIT_WORDS = 3;
  localparam int MAX_CYC = 20000;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [NP-1:0] in_push = '0, out_pop = '0, out_avail;
  logic [NP-1:0][WORD_W-1:0] in_word = '0, out_word;
  logic fire;

  stall_wrapper u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_push_i(in_push), .in_word_i(in_word),
    .out_pop_i(out_pop), .out_word_o(out_word), .out_avail_o(out_avail), .fire_o(fire)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference model
  logic [WORD_W-1:0] mq_in [NP][$];
  logic [WORD_W-1:0] mq_out[NP][$];
  int m_space[NP];
  int m_ph = 0, m_init = INIT_WORDS;
  bit pdv[LAT];
  logic [WORD_W-1:0] pdw[LAT][NP];

  function automatic bit m_fire();
    if (m_init > 0) return 0;
    if (m_ph != 0) return 1;
    for (int p = 0; p < NP; p++)
      if (mq_in[p].size() < FW || m_space[p] < FW) return 0;
    return 1;
  endfunction

  task automatic model_step();
    bit f;
    logic [WORD_W-1:0] fw[NP];
    f = m_fire();
    for (int p = 0; p < NP; p++) begin
      fw[p] = f ? mq_in[p].pop_front() : '0;
      if (in_push[p] && mq_in[p].size() < DEPTH) mq_in[p].push_back(in_word[p]);
      if (out_pop[p] && mq_out[p].size() > 0) begin
        void'(mq_out[p].pop_front());
        m_space[p]++;
      end
      if (m_init > 0) mq_out[p].push_back('0);
      else if (pdv[LAT-1]) mq_out[p].push_back(pdw[LAT-1][p]);
      if (f) m_space[p]--;
    end
    for (int k = LAT-1; k > 0; k--) begin
      pdv[k] = pdv[k-1];
      pdw[k] = pdw[k-1];
    end
    pdv[0] = f;
    pdw[0] = fw;
    m_ph = f ? ((m_ph == FW-1) ? 0 : m_ph + 1) : 0;
    if (m_init > 0) m_init--;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit ef;
    ef = m_fire();
    chk(fire == ef, "R3/R6 fire", fire, ef);
    for (int p = 0; p < NP; p++) begin
      chk(out_avail[p] == (mq_out[p].size() > 0), "R7 avail", out_avail[p], mq_out[p].size() > 0);
      if (mq_out[p].size() > 0) begin
        if (mq_out[p][0][DATA_W] == 1'b0)
          chk(out_word[p] == mq_out[p][0], "R8 empty token", out_word[p], mq_out[p][0]);
        else
          chk(out_word[p] == mq_out[p][0], "R5/R7 word", out_word[p], mq_out[p][0]);
      end
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int p = 0; p < NP; p++) m_space[p] = DEPTH - INIT_WORDS;
    for (int k = 0; k < LAT; k++) pdv[k] = 0;
    repeat (3) @(negedge clk_i);
    chk(fire == 1'b0, "R1 fire in reset", fire, 0);
    chk(out_avail == '0, "R1 avail in reset", out_avail, 0);
    rst_ni = 1'b1;

    // R2: init tokens, nothing drained
    repeat (3) cyc();
    chk(out_avail == 2'b11, "R2 init tokens present", out_avail, 3);
    chk(out_word[0] == '0 && out_word[1] == '0, "R2 init token zero", out_word, 0);
    chk(fire == 1'b0, "R2 no fire", fire, 0);

    // drain init tokens plus extra pops on empty (R10)
    out_pop = 2'b11;
    repeat (6) cyc();
    out_pop = '0;
    chk(out_avail == '0, "R10 pop on empty ignored", out_avail, 0);

    // R3/R8: two words only, port0 carries empty tokens
    in_push = 2'b11;
    for (int k = 0; k < 2; k++) begin
      in_word[0] = 9'h0A0 + 9'(k);
      in_word[1] = 9'h110 + 9'(k);
      cyc();
    end
    in_push = '0;
    cyc();
    chk(fire == 1'b0, "R3 partial flit no fire", fire, 0);
    in_push = 2'b11;
    in_word[0] = 9'h0A2;
    in_word[1] = 9'h112;
    cyc();
    in_push = '0;
    chk(fire == 1'b1, "R3 whole flit fires", fire, 1);
    cyc();
    chk(fire == 1'b1, "R4 fire second cycle", fire, 1);
    cyc();
    chk(fire == 1'b1, "R4 fire third cycle", fire, 1);
    chk(out_avail == '0, "R7 not before latency", out_avail, 0);
    cyc();
    chk(fire == 1'b0, "R4 fire ends after flit", fire, 0);
    chk(out_avail == 2'b11, "R7 word at latency", out_avail, 3);
    chk(out_word[0] == 9'h0A0, "R8 empty token unchanged", out_word[0], 9'h0A0);
    chk(out_word[1] == 9'h110, "R7 first data word", out_word[1], 9'h110);

    // R6: reservation at forwarding time
    in_push = 2'b11;
    for (int k = 3; k < 6; k++) begin
      in_word[0] = 9'h130 + 9'(k);
      in_word[1] = 9'h150 + 9'(k);
      cyc();
    end
    chk(fire == 1'b1, "R6 fire with space 3", fire, 1);
    for (int k = 6; k < 9; k++) begin
      in_word[0] = 9'h130 + 9'(k);
      in_word[1] = 9'h150 + 9'(k);
      cyc();
    end
    in_push = '0;
    chk(fire == 1'b0, "R6 blocked by reservation", fire, 0);
    out_pop = 2'b11;
    repeat (20) cyc();

    // R9: overfill port0 while port1 empty
    in_push = 2'b01;
    for (int k = 0; k < 8; k++) begin
      in_word[0] = 9'h170 + 9'(k);
      cyc();
    end
    chk(fire == 1'b0, "R3 one starved input", fire, 0);
    in_push = 2'b10;
    for (int k = 0; k < 9; k++) begin
      in_word[1] = 9'h190 + 9'(k);
      cyc();
    end
    in_push = '0;
    repeat (4) cyc();
    chk(fire == 1'b0, "R9 dropped words not stored", fire, 0);
    in_push = 2'b01;
    repeat (3) cyc();
    in_push = '0;
    repeat (10) cyc();

    // random traffic with back-to-back flits (R4/R5/R7)
    for (int i = 0; i < 3000; i++) begin
      for (int p = 0; p < NP; p++) begin
        in_push[p] = ($urandom % 4) != 0;
        in_word[p] = {1'(($urandom % 5) != 0), 8'($urandom)};
        out_pop[p] = ($urandom % 3) != 0;
      end
      cyc();
    end
    in_push = '0;
    out_pop = 2'b11;
    repeat (40) cyc();
    chk(out_avail == '0, "R11 outputs drained", out_avail, 0);
    finish_run();
  end
endmodule